// File: doc/BRIEF.md
# Manchester Line Encoder with Rising-Edge Frame Close

This block turns a serial NRZ bit stream into a Manchester-coded, single-ended line level for a 10 Mb/s twisted-pair transmitter. It runs from one oversampling clock at twice the bit rate. From that clock it produces the bit-rate transmit clock, which it drives out, and it updates the line once per half-bit. While the transmit enable is high, the block takes one data bit on every rising edge of the transmit clock and drives that bit as two half-cells.

When the enable is seen low at a bit boundary, the frame is closed so that its last line transition is a rising edge. After a one, that rising edge has already happened in the middle of the last cell. After a zero, it happens at the cell boundary. The line then stays high for a fixed hold of `HOLD_BITS` bit times. After that it returns to a low idle level and the idle flag is raised. An enable raised during the hold has no effect until the hold is over.

Top module: `manchester_tx_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to `line_out`=0, `tx_clk`=0, `busy`=0 and `idle`=1. This also applies when reset is applied in the middle of a frame.
- R2: `tx_clk` changes level on every clock edge, so it runs at half the clock rate. Its rising edges are the bit boundaries at which inputs are sampled.
- R3: A frame starts only at a rising edge of `tx_clk` at which `tx_en` is high. `tx_en` raised while `tx_clk` is high has no effect on the line before the next rising edge of `tx_clk`.
- R4: Each sampled bit occupies two clock cycles. A one is sent as low then high, and a zero as high then low. The first half-cell is visible one clock after the sampling edge.
- R5: When `tx_en` is low at a rising edge of `tx_clk` during a frame, the frame ends and `line_out` is high from that boundary. If the last bit was a zero, the closing rising edge falls on that boundary. If the last bit was a one, the line already went high at the middle of the last cell and stays high.
- R6: After the frame ends, `line_out` stays high for `HOLD_BITS` bit times (4 clocks at the default of 2). It then drops to 0 and `idle` rises.
- R7: `tx_en` held high during the hold is ignored. The next frame starts at the first rising edge of `tx_clk` after `idle` has risen.
- R8: `busy` is high from the first encoded half-cell until the hold has ended. `idle` is always the inverse of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; frame runs while high |
| tx_d | input | 1 | NRZ data bit, sampled at tx_clk rising edge |
| tx_clk | output | 1 | Bit-rate transmit clock, half of clk |
| line_out | output | 1 | Manchester line level |
| busy | output | 1 | Frame or closing hold in progress |
| idle | output | 1 | Encoder idle, line parked low |

## Verification
Two things can land on the same `tx_clk` rising edge: the expiry of the closing hold and a transmit enable that has been waiting since the middle of the hold. The bench raises `tx_en` with a one on `tx_d` two clocks into the hold and keeps it high. It then checks that the line stays high through the ignored edges and that the edge where the hold expires parks the line low with `idle` set. The frame must start only one bit later, with a low first half-cell. The bench also covers a frame ending at the same edge that would otherwise sample a new bit, for both polarities of the last bit.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester transmit encoder.
package mtx_pkg;
    // Encoder sequencing: waiting, coding bits, holding the line high after close.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HOLD = 2'd2
    } enc_state_t;
endpackage

// File: rtl/mtx_phase.sv
// Half-rate phase generator.
// Toggles every clock to form the bit-rate transmit clock. sample_now is
// high in the cycle whose closing edge is a rising edge of the phase
// (a bit boundary). Assumes synchronous active-low reset.
module mtx_phase (
    input  logic clk,
    input  logic rst_n,
    output logic ph,
    output logic sample_now
);
    // Phase register: flips each clock, parked low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    // Bit boundary: next edge raises the phase.
    assign sample_now = ~ph;

    assert_ph_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph |=> !ph);
    assert_ph_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ph |=> ph);
endmodule

// File: rtl/mtx_hold_timer.sv
// Post-frame hold timer, counted in bit times.
// load starts a hold of HOLD_BITS bits; tick marks each bit boundary;
// done pulses on the boundary that ends the hold. Assumes HOLD_BITS >= 1.
module mtx_hold_timer #(
    parameter int HOLD_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(HOLD_BITS + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(HOLD_BITS);

    logic [CW-1:0] cnt;

    // Remaining-bit counter: loaded at frame close, counts down on boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= LOAD_V;
        else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Expiry on the boundary that consumes the last remaining bit.
    assign done = tick && (cnt == CW'(1));

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_V);
    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (cnt == '0));
endmodule

// File: rtl/manchester_tx_encoder.sv
// Manchester transmit encoder with rising-edge frame close.
// Samples tx_d at each tx_clk rising edge while tx_en is high and drives
// two half-cells per bit (one = low,high; zero = high,low). On a boundary
// with tx_en low it forces the line high, holds it HOLD_BITS bit times,
// then parks it low. Assumes one clock at twice the bit rate and a
// synchronous active-low reset.
module manchester_tx_encoder
    import mtx_pkg::*;
#(
    parameter int HOLD_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_d,
    output logic tx_clk,
    output logic line_out,
    output logic busy,
    output logic idle
);
    enc_state_t state;
    logic ph, sample_now;
    logic line_q, last_q;
    logic hold_load, hold_tick, hold_done;

    mtx_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .sample_now (sample_now)
    );

    // Hold control: start on frame close, step on each bit boundary.
    always_comb begin
        hold_load = sample_now && (state == ST_DATA) && !tx_en;
        hold_tick = sample_now && (state == ST_HOLD);
    end

    mtx_hold_timer #(.HOLD_BITS(HOLD_BITS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .tick  (hold_tick),
        .done  (hold_done)
    );

    // Sequencer and line register: one half-cell per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            line_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sample_now && tx_en) begin
                        state  <= ST_DATA;
                        line_q <= ~tx_d;
                        last_q <= tx_d;
                    end else begin
                        line_q <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (!sample_now) begin
                        line_q <= last_q;
                    end else if (tx_en) begin
                        line_q <= ~tx_d;
                        last_q <= tx_d;
                    end else begin
                        line_q <= 1'b1;
                        state  <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (hold_done) begin
                        state  <= ST_IDLE;
                        line_q <= 1'b0;
                    end else begin
                        line_q <= 1'b1;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    line_q <= 1'b0;
                end
            endcase
        end
    end

    // Output mapping.
    assign tx_clk   = ph;
    assign line_out = line_q;
    assign busy     = (state != ST_IDLE);
    assign idle     = (state == ST_IDLE);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sample_now && tx_en) |=> (busy && line_out == !$past(tx_d)));
    assert_no_start_off_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sample_now) |=> idle);
    assert_mid_transition_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !sample_now) |=> (line_out != $past(line_out)));
    assert_close_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && sample_now && !tx_en) |=> (line_out && busy));
    assert_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> line_out);
    assert_hold_ignores_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state != ST_DATA));
    assert_busy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy ^ idle);
endmodule

// File: tb/manchester_tx_encoder_bench.sv
module manchester_tx_encoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic tx_d = 1'b0;
    logic tx_clk, line_out, busy, idle;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    manchester_tx_encoder #(.HOLD_BITS(2)) u_manchester_tx_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_d     (tx_d),
        .tx_clk   (tx_clk),
        .line_out (line_out),
        .busy     (busy),
        .idle     (idle)
    );

    // Frame table: bits sent LSB first, with length.
    localparam logic [15:0] PATS [8] = '{16'h0001, 16'h0000, 16'hA5A5, 16'hFFFF,
                                         16'h0000, 16'h00F0, 16'h0155, 16'h0ABC};
    localparam int LENS [8] = '{1, 1, 16, 5, 6, 8, 9, 12};

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Move to a falling clock edge after which the next rising edge is a bit boundary.
    task automatic wait_sample();
        @(negedge clk);
        while (tx_clk !== 1'b0) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] pat, input int len);
        wait_sample();
        chk("R8 idle before frame", idle, 1'b1);
        for (int i = 0; i < len; i++) begin
            tx_en = 1'b1;
            tx_d  = pat[i];
            @(negedge clk);
            chk("R4 first half", line_out, ~pat[i]);
            chk("R8 busy in frame", busy, 1'b1);
            @(negedge clk);
            chk("R4 second half", line_out, pat[i]);
        end
        tx_en = 1'b0;
        tx_d  = ~pat[len-1];
        @(negedge clk);
        chk("R5 closing level high", line_out, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 hold high", line_out, 1'b1);
            chk("R8 busy in hold", busy, 1'b1);
        end
        @(negedge clk);
        chk("R6 drop to idle", line_out, 1'b0);
        chk("R6 idle flag", idle, 1'b1);
        chk("R8 busy cleared", busy, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic prev;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 line in reset", line_out, 1'b0);
        chk("R1 tx_clk in reset", tx_clk, 1'b0);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 idle in reset", idle, 1'b1);
        rst_n = 1'b1;

        // R2 transmit clock toggles each clock
        @(negedge clk);
        prev = tx_clk;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R2 tx_clk toggles", tx_clk, ~prev);
            prev = tx_clk;
        end

        // Table walk: R4 R5 R6 R8 across patterns
        for (int v = 0; v < 8; v++) send_frame(PATS[v], LENS[v]);

        // R3 enable raised off-boundary does not start early
        wait_sample();
        @(negedge clk);
        tx_en = 1'b1;
        tx_d  = 1'b0;
        @(negedge clk);
        chk("R3 no start off boundary line", line_out, 1'b0);
        chk("R3 no start off boundary idle", idle, 1'b1);
        @(negedge clk);
        chk("R3 start at boundary", line_out, 1'b1);
        chk("R3 busy at boundary", busy, 1'b1);
        @(negedge clk);
        chk("R4 zero second half", line_out, 1'b0);

        // R7 enable during hold is ignored until hold expiry
        tx_en = 1'b0;
        @(negedge clk);
        chk("R5 rise at boundary after zero", line_out, 1'b1);
        @(negedge clk);
        tx_en = 1'b1;
        tx_d  = 1'b1;
        @(negedge clk);
        chk("R7 hold ignores enable", line_out, 1'b1);
        @(negedge clk);
        chk("R7 hold still high", line_out, 1'b1);
        @(negedge clk);
        chk("R7 expiry wins line", line_out, 1'b0);
        chk("R7 expiry sets idle", idle, 1'b1);
        @(negedge clk);
        chk("R7 still idle", idle, 1'b1);
        @(negedge clk);
        chk("R7 late start busy", busy, 1'b1);
        chk("R7 late start first half", line_out, 1'b0);
        @(negedge clk);
        chk("R7 late start second half", line_out, 1'b1);
        tx_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 idle after late frame", idle, 1'b1);

        // R1 reset in mid-frame
        wait_sample();
        tx_en = 1'b1;
        tx_d  = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset line", line_out, 1'b0);
        chk("R1 mid-frame reset busy", busy, 1'b0);
        chk("R1 mid-frame reset tx_clk", tx_clk, 1'b0);
        chk("R1 mid-frame reset idle", idle, 1'b1);
        tx_en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule